// File: doc/BRIEF.md
# Flag-Driven Next-PC Selector

This combinational block decides where a single-cycle processor fetches next. It takes the current program counter, the 16-bit immediate and 26-bit jump field of the instruction in flight, a branch enable, a jump enable, and a 4-bit condition code. It also takes the four status flags that the ALU produced while it subtracted the second operand from the first. From the flags it evaluates one of ten signed or unsigned comparison conditions. It then returns the next PC: the jump target, the branch target, or the sequential address PC+4.

The branch decision is not limited to the zero flag. Every ordering test on two's-complement and unsigned operands is available, and a branch instruction only has to choose a condition code. The PC register, the instruction decoder and the ALU are outside this block. The decoder drives the enables and the condition code, and the PC register captures the `npc_o` output.

Top module: `branch_npc_unit`

## Requirements
- R1: When the jump enable is low and the branch is not taken, `npc_o` equals `pc_i + 4`, wrapping modulo 2^ADDR_W.
- R2: When the jump enable is low and the branch is taken, `npc_o` equals `(pc_i + 4) + (sign-extended imm_i << 2)`, wrapping modulo 2^ADDR_W.
- R3: When the jump enable is high, `npc_o` is `{(pc_i+4)[31:28], jfield_i, 2'b00}`, whatever the branch enable and the condition are.
- R4: The signed conditions are: code 2 is less-than (N xor V), code 3 is less-or-equal (Z or (N xor V)), code 4 is greater-than (not (Z or (N xor V))), and code 5 is greater-or-equal (not (N xor V)).
- R5: Code 0 is equal (Z) and code 1 is not-equal (not Z). With code 0, `br_take_o` equals the branch enable ANDed with Z.
- R6: The unsigned conditions, with carry taken from A + ~B + 1, are: code 6 is lower (not C), code 7 is lower-or-same (not C or Z), code 8 is higher (C and not Z), and code 9 is higher-or-same (C).
- R7: Codes 10 to 15 evaluate to false. With a branch enabled, `br_take_o` is low and `npc_o` is `pc_i + 4`.
- R8: `br_take_o` is the branch enable ANDed with the selected condition. When the branch enable is low, `br_take_o` is low for any flags and any code. This holds even when the jump enable is high.
- R9: `flags_i` is packed as {Z, V, C, N}: Z is bit 3, V is bit 2, C is bit 1 and N is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | ADDR_W (32) | Current program counter |
| imm_i | input | IMM_W (16) | Branch offset in words, two's complement |
| jfield_i | input | JF_W (26) | Word index inside the current 256 MB region |
| br_en_i | input | 1 | Instruction is a conditional branch |
| jmp_en_i | input | 1 | Instruction is an unconditional jump |
| cond_sel_i | input | 4 | Condition code, 0 to 9 used |
| flags_i | input | 4 | ALU flags {Z, V, C, N} from A minus B |
| npc_o | output | ADDR_W (32) | Next program counter |
| br_take_o | output | 1 | Branch enable ANDed with the selected condition |

## Verification
Several corner cases are hard to reach from the ports. One is a branch target that moves backwards across address zero. Another is a jump issued from the last word of a 256 MB region, where the upper four bits must come from PC+4 and not from the PC. A third is a flag pattern that makes the signed and unsigned verdicts disagree. Directed vectors cover these: a PC of 0x0FFFFFFC, offsets of 0x8000 and 0x7FFF, and PCs near the top of the address space. An exhaustive sweep also covers all sixteen condition codes against all sixteen flag patterns, under every combination of the two enables, with random PC, immediate and jump field values.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;

    localparam int CC_W   = 4;
    localparam int NUM_CC = 10;

    typedef enum logic [CC_W-1:0] {
        CC_EQ  = 4'd0,
        CC_NE  = 4'd1,
        CC_LT  = 4'd2,
        CC_LE  = 4'd3,
        CC_GT  = 4'd4,
        CC_GE  = 4'd5,
        CC_LTU = 4'd6,
        CC_LEU = 4'd7,
        CC_GTU = 4'd8,
        CC_GEU = 4'd9
    } cc_e;

    // Packed so that z lands in bit 3 and n in bit 0 (R9)
    typedef struct packed {
        logic z;
        logic v;
        logic c;
        logic n;
    } flags_t;

endpackage

// File: rtl/npc_cond_eval.sv
`timescale 1ns/1ps
module npc_cond_eval
    import npc_pkg::*;
(
    input  logic [CC_W-1:0] sel_i,
    input  flags_t          flags_i,
    output logic            cond_o
);

    localparam int NUM_CODES = 2 ** CC_W;

    logic [NUM_CC-1:0]    used_d;
    logic [NUM_CODES-1:0] all_d;
    logic                 slt_d;

    always_comb begin
        slt_d = flags_i.n ^ flags_i.v;
        used_d = '0;
        used_d[int'(CC_EQ)]  = flags_i.z;
        used_d[int'(CC_NE)]  = ~flags_i.z;
        used_d[int'(CC_LT)]  = slt_d;
        used_d[int'(CC_LE)]  = flags_i.z | slt_d;
        used_d[int'(CC_GT)]  = ~(flags_i.z | slt_d);
        used_d[int'(CC_GE)]  = ~slt_d;
        used_d[int'(CC_LTU)] = ~flags_i.c;
        used_d[int'(CC_LEU)] = ~flags_i.c | flags_i.z;
        used_d[int'(CC_GTU)] = flags_i.c & ~flags_i.z;
        used_d[int'(CC_GEU)] = flags_i.c;
    end

    // Spread the defined codes across the full code space; spare codes are false
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        if (g < NUM_CC) begin : g_used
            assign all_d[g] = used_d[g];
        end else begin : g_spare
            assign all_d[g] = 1'b0;
        end
    end

    assign cond_o = all_d[sel_i];

endmodule

// File: rtl/npc_target_gen.sv
`timescale 1ns/1ps
module npc_target_gen #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int JF_W   = 26
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [JF_W-1:0]   jfield_i,
    output logic [ADDR_W-1:0] pc4_o,
    output logic [ADDR_W-1:0] bta_o,
    output logic [ADDR_W-1:0] jta_o
);

    localparam int SEXT_W = ADDR_W - IMM_W - 2;
    localparam int HI_W   = ADDR_W - JF_W - 2;

    logic [ADDR_W-1:0] off_d;

    always_comb begin
        pc4_o = pc_i + ADDR_W'(4);
        off_d = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
        bta_o = pc4_o + off_d;
        jta_o = {pc4_o[ADDR_W-1 -: HI_W], jfield_i, 2'b00};
    end

endmodule

// File: rtl/npc_select.sv
`timescale 1ns/1ps
module npc_select #(
    parameter int ADDR_W = 32
) (
    input  logic              br_en_i,
    input  logic              jmp_en_i,
    input  logic              cond_i,
    input  logic [ADDR_W-1:0] pc4_i,
    input  logic [ADDR_W-1:0] bta_i,
    input  logic [ADDR_W-1:0] jta_i,
    output logic [ADDR_W-1:0] npc_o,
    output logic              take_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] npc;
        logic              take;
    } sel_t;

    sel_t sel_d;

    always_comb begin
        sel_d.take = br_en_i & cond_i;
        if (jmp_en_i)
            sel_d.npc = jta_i;
        else if (sel_d.take)
            sel_d.npc = bta_i;
        else
            sel_d.npc = pc4_i;
    end

    assign npc_o  = sel_d.npc;
    assign take_o = sel_d.take;

endmodule

// File: rtl/branch_npc_unit.sv
`timescale 1ns/1ps
module branch_npc_unit
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int JF_W   = 26
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [JF_W-1:0]   jfield_i,
    input  logic              br_en_i,
    input  logic              jmp_en_i,
    input  logic [3:0]        cond_sel_i,
    input  logic [3:0]        flags_i,
    output logic [ADDR_W-1:0] npc_o,
    output logic              br_take_o
);

    logic [ADDR_W-1:0] pc4_d, bta_d, jta_d;
    logic              cond_d;
    flags_t            flags_d;

    assign flags_d = flags_t'(flags_i);

    npc_cond_eval u_cond (
        .sel_i   (cond_sel_i),
        .flags_i (flags_d),
        .cond_o  (cond_d)
    );

    npc_target_gen #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .JF_W   (JF_W)
    ) u_tgt (
        .pc_i     (pc_i),
        .imm_i    (imm_i),
        .jfield_i (jfield_i),
        .pc4_o    (pc4_d),
        .bta_o    (bta_d),
        .jta_o    (jta_d)
    );

    npc_select #(
        .ADDR_W (ADDR_W)
    ) u_sel (
        .br_en_i  (br_en_i),
        .jmp_en_i (jmp_en_i),
        .cond_i   (cond_d),
        .pc4_i    (pc4_d),
        .bta_i    (bta_d),
        .jta_i    (jta_d),
        .npc_o    (npc_o),
        .take_o   (br_take_o)
    );

endmodule

// File: rtl/branch_npc_unit_chk.sv
`timescale 1ns/1ps
module branch_npc_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int JF_W   = 26
) (
    input logic [ADDR_W-1:0] pc_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [JF_W-1:0]   jfield_i,
    input logic              br_en_i,
    input logic              jmp_en_i,
    input logic [3:0]        cond_sel_i,
    input logic [3:0]        flags_i,
    input logic [ADDR_W-1:0] npc_o,
    input logic              br_take_o
);

    localparam int SEXT_W = ADDR_W - IMM_W - 2;

    logic [ADDR_W-1:0] seq_c;
    logic [ADDR_W-1:0] off_c;

    always_comb begin
        seq_c = pc_i + ADDR_W'(4);
        off_c = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};

        if (!jmp_en_i && !br_take_o) begin
            p_seq_r1: assert (npc_o == seq_c)
                else $error("R1 sequential address wrong");
        end
        if (!jmp_en_i && br_take_o) begin
            p_btgt_r2: assert (npc_o == seq_c + off_c)
                else $error("R2 branch target wrong");
        end
        if (jmp_en_i) begin
            p_jump_r3: assert (npc_o[JF_W+1:0] == {jfield_i, 2'b00})
                else $error("R3 jump target wrong");
        end
        if (br_en_i && cond_sel_i == 4'd0) begin
            p_eq_r5: assert (br_take_o == flags_i[3])
                else $error("R5 equal test not on Z");
        end
        if (cond_sel_i >= 4'd10) begin
            p_spare_r7: assert (!br_take_o)
                else $error("R7 spare code taken");
        end
        if (!br_en_i) begin
            p_noen_r8: assert (!br_take_o)
                else $error("R8 taken without enable");
        end
    end

endmodule

bind branch_npc_unit branch_npc_unit_chk #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .JF_W   (JF_W)
) u_chk (.*);

// File: tb/branch_npc_unit_bench.sv
`timescale 1ns/1ps
module branch_npc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc;
    logic [15:0] imm;
    logic [25:0] jf;
    logic        br_en, jmp_en;
    logic [3:0]  sel, fl;
    logic [31:0] npc;
    logic        take;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    branch_npc_unit u_branch_npc_unit (
        .pc_i       (pc),
        .imm_i      (imm),
        .jfield_i   (jf),
        .br_en_i    (br_en),
        .jmp_en_i   (jmp_en),
        .cond_sel_i (sel),
        .flags_i    (fl),
        .npc_o      (npc),
        .br_take_o  (take)
    );

    // Reference: condition verdict from the requirement text
    function automatic bit ref_cond(int code, logic [3:0] f);
        bit z = f[3], v = f[2], c = f[1], n = f[0];
        bit less = (n != v);
        case (code)
            0: return z;
            1: return !z;
            2: return less;
            3: return z || less;
            4: return !(z || less);
            5: return !less;
            6: return !c;
            7: return !c || z;
            8: return c && !z;
            9: return c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(bit j, bit b, int code);
        if (j) return "R3";
        if (!b) return "R8";
        if (code <= 1) return "R5";
        if (code <= 5) return "R4";
        if (code <= 9) return "R6";
        return "R7";
    endfunction

    task automatic apply(input logic [31:0] p, input logic [15:0] im,
                         input logic [25:0] j, input bit b, input bit jm,
                         input int code, input logic [3:0] f, input string why);
        longint unsigned seq, exp_npc;
        bit exp_take;
        string t;
        @(posedge clk);
        #1;
        pc = p; imm = im; jf = j; br_en = b; jmp_en = jm;
        sel = code[3:0]; fl = f;
        seq = (longint'(p) + 4) & 64'hFFFF_FFFF;
        exp_take = b && ref_cond(code, f);
        if (jm)
            exp_npc = {seq[31:28], j, 2'b00};
        else if (exp_take)
            exp_npc = (seq + longint'($signed(im)) * 4) & 64'hFFFF_FFFF;
        else
            exp_npc = seq;
        t = (why.len() > 0) ? why : tag_of(jm, b, code);
        @(negedge clk);
        n_run++;
        if (npc !== exp_npc[31:0]) begin
            n_fail++;
            $display("FAIL %s npc: got %h expected %h (code %0d flags %b br %0b jmp %0b)",
                     t, npc, exp_npc[31:0], code, f, b, jm);
        end
        n_run++;
        if (take !== exp_take) begin
            n_fail++;
            $display("FAIL %s take: got %0b expected %0b (code %0d flags %b br %0b)",
                     t, take, exp_take, code, f, b);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        pc = '0; imm = '0; jf = '0; br_en = 0; jmp_en = 0; sel = '0; fl = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-time inputs all zero: sequential fetch to address 4 (R1)
        apply(32'h0, 16'h0, 26'h0, 0, 0, 0, 4'h0, "R1");
        // R1 wrap at the top of the address space
        apply(32'hFFFF_FFFC, 16'h0010, 26'h0, 0, 0, 0, 4'h0, "R1");
        // R2 forward, backward max, backward across zero
        apply(32'h0000_1000, 16'h7FFF, 26'h0, 1, 0, 0, 4'b1000, "R2");
        apply(32'h0000_1000, 16'h8000, 26'h0, 1, 0, 0, 4'b1000, "R2");
        apply(32'h0000_0008, 16'hFFF0, 26'h0, 1, 0, 1, 4'b0000, "R2");
        // R3 jump from last word of a region: upper bits from PC+4
        apply(32'h0FFF_FFFC, 16'h0004, 26'h3FF_FFFF, 1, 1, 0, 4'b1000, "R3");
        apply(32'hF000_0000, 16'h0004, 26'h0000123, 0, 1, 0, 4'b0000, "R3");
        // R9 field positions: one flag at a time against single-flag codes
        apply(32'h100, 16'h4, 26'h0, 1, 0, 0, 4'b1000, "R9");  // Z -> EQ
        apply(32'h100, 16'h4, 26'h0, 1, 0, 2, 4'b0100, "R9");  // V -> LT
        apply(32'h100, 16'h4, 26'h0, 1, 0, 9, 4'b0010, "R9");  // C -> GEU
        apply(32'h100, 16'h4, 26'h0, 1, 0, 2, 4'b0001, "R9");  // N -> LT
        // Signed and unsigned verdicts disagree: N=1, C=1
        apply(32'h200, 16'h8, 26'h0, 1, 0, 2, 4'b0011, "R4");
        apply(32'h200, 16'h8, 26'h0, 1, 0, 6, 4'b0011, "R6");
        // R7 spare codes with every flag set
        apply(32'h300, 16'h8, 26'h0, 1, 0, 15, 4'b1111, "R7");
        // Exhaustive code x flags x enables with random addresses
        for (int code = 0; code < 16; code++)
            for (int f = 0; f < 16; f++)
                for (int e = 0; e < 4; e++)
                    apply($urandom() & 32'hFFFF_FFFC, 16'($urandom()),
                          26'($urandom()), e[0], e[1], code, f[3:0], "");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule